// File: doc/BRIEF.md
# Output Bank with Protection Timeout

This block drives a bank of digital outputs, eight by default. Each output has a control byte and a 16-bit protection time in seconds, both held in a small byte-wide register file. Set and clear commands carry a bit mask in which bit i selects output i. An output that is enabled and armed counts down once per one-second tick while it is high. If no command reaches that output before the count runs out, the block forces the output low and raises a one-cycle alarm strobe for that channel.

The control byte also supplies the state of the output while it is disabled. A disabled output holds the level given by control bit 0 and ignores all commands. Each output has its own on, off and alarm strobes, so several channels can report in the same cycle. A host writes the configuration through the register port and sends commands through the mask inputs. A timebase supplies the tick.

Top module: `outbank_guard`

## Requirements
- R1: For as long as `rst` is high at a clock edge, all outputs and all strobes are low, and every register reads 0 afterwards.
- R2: The control byte of output i is at address i. Its protection time MSB is at address N_OUT+2i and its LSB at address N_OUT+2i+1. `rd_data` shows the register addressed by `rd_addr` one cycle later, and unmapped addresses read 0.
- R3: A write to the time MSB is staged only. The staged MSB and the written LSB become the active time together, on the LSB write. Until then the MSB address reads the previous time.
- R4: While control bit 7 is 0 the output is disabled. It takes the value of control bit 0 one cycle after the control register changes, and set and clear commands have no effect on it.
- R5: While enabled, a 1 in `set_mask` bit i drives output i high on the next edge and a 1 in `clr_mask` bit i drives it low. When both bits are set, clear wins.
- R6: If control bit 2 is 1 and the protection time T is not 0, an output raised by a command goes low after T ticks with no further command. In that same cycle `alarm_evt` for that channel pulses for exactly one cycle.
- R7: Every set or clear command to an enabled output reloads its countdown from the active protection time.
- R8: With a protection time of 0, or with control bit 2 at 0, an output never times out.
- R9: `on_evt[i]` pulses for one cycle in the cycle output i goes from low to high, and `off_evt[i]` in the cycle it goes from high to low. This includes a drop caused by a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Read data, one cycle after `rd_addr` |
| set_mask | input | N_OUT | Drive selected outputs high |
| clr_mask | input | N_OUT | Drive selected outputs low |
| tick_1s | input | 1 | One-cycle pulse, once per second |
| out_pins | output | N_OUT | Output levels |
| on_evt | output | N_OUT | Per-channel low-to-high strobe |
| off_evt | output | N_OUT | Per-channel high-to-low strobe |
| alarm_evt | output | N_OUT | Per-channel timeout strobe |

## Verification
The hardest state to reach is the exact expiry cycle while a restart competes with it. The bench loads a short three-second time, counts ticks one by one, and checks that the output is still high after the second tick. It then sends a fresh set command just before expiry, to show that the countdown restarts rather than continuing. Separate channels with a zero time or a cleared arm bit receive more ticks than the programmed time, to show that no timeout occurs. The staged-MSB behaviour is exposed by reading the MSB address between the two halves of a time write.

// File: rtl/outbank_pkg.sv
package outbank_pkg;
  localparam int CTL_INIT = 0;
  localparam int CTL_PROT = 2;
  localparam int CTL_EN   = 7;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/outbank_regs.sv
module outbank_regs
  import outbank_pkg::*;
#(
  parameter int N_OUT  = 8,
  parameter int TIME_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  byte_t                         wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  output byte_t                         rd_data,
  output byte_t [N_OUT-1:0]             ctrl_o,
  output logic  [N_OUT-1:0][TIME_W-1:0] ptime_o
);
  localparam int HI_W = TIME_W - 8;

  byte_t [N_OUT-1:0]             ctrl_q;
  logic  [N_OUT-1:0][TIME_W-1:0] ptime_q;
  logic  [N_OUT-1:0][HI_W-1:0]   stage_q;
  byte_t                         rd_q;

  for (genvar i = 0; i < N_OUT; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(i);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(N_OUT + 2*i);
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(N_OUT + 2*i + 1);

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[i]  <= '0;
        ptime_q[i] <= '0;
        stage_q[i] <= '0;
      end else if (wr_en) begin
        if (wr_addr == A_CTL) ctrl_q[i]  <= wr_data;
        if (wr_addr == A_HI)  stage_q[i] <= wr_data[HI_W-1:0];
        if (wr_addr == A_LO)  ptime_q[i] <= {stage_q[i], wr_data};
      end
    end
  end

  always_comb begin
    byte_t v;
    v = '0;
    for (int i = 0; i < N_OUT; i++) begin
      if (rd_addr == ADDR_W'(i))             v = ctrl_q[i];
      if (rd_addr == ADDR_W'(N_OUT + 2*i))   v = 8'(ptime_q[i][TIME_W-1:8]);
      if (rd_addr == ADDR_W'(N_OUT + 2*i+1)) v = ptime_q[i][7:0];
    end
    rd_next = v;
  end

  byte_t rd_next;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end

  assign rd_data = rd_q;
  assign ctrl_o  = ctrl_q;
  assign ptime_o = ptime_q;

  // R3: active time changes only on an LSB write
  for (genvar i = 0; i < N_OUT; i++) begin : g_chk
    assert_time_commit_R3: assert property (@(posedge clk) disable iff (rst)
      (ptime_q[i] != $past(ptime_q[i])) |->
        ($past(wr_en) && $past(wr_addr) == ADDR_W'(N_OUT + 2*i + 1)));
  end
endmodule

// File: rtl/outbank_chan.sv
module outbank_chan
  import outbank_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  byte_t             ctrl_i,
  input  logic [TIME_W-1:0] ptime_i,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic              tick_i,
  output logic              out_o,
  output logic              on_o,
  output logic              off_o,
  output logic              alarm_o
);
  logic              out_q, out_n;
  logic [TIME_W-1:0] cnt_q, cnt_n;
  logic              alm_n;
  logic              on_q, off_q, alm_q;
  logic              en, armed;

  assign en    = ctrl_i[CTL_EN];
  assign armed = ctrl_i[CTL_PROT] && (ptime_i != '0);

  always_comb begin
    out_n = out_q;
    cnt_n = cnt_q;
    alm_n = 1'b0;
    if (!en) begin
      out_n = ctrl_i[CTL_INIT];
      cnt_n = '0;
    end else if (clr_i) begin
      out_n = 1'b0;
      cnt_n = ptime_i;
    end else if (set_i) begin
      out_n = 1'b1;
      cnt_n = ptime_i;
    end else if (tick_i && out_q && armed && cnt_q != '0) begin
      if (cnt_q == TIME_W'(1)) begin
        out_n = 1'b0;
        cnt_n = '0;
        alm_n = 1'b1;
      end else begin
        cnt_n = cnt_q - TIME_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      cnt_q <= '0;
      on_q  <= 1'b0;
      off_q <= 1'b0;
      alm_q <= 1'b0;
    end else begin
      out_q <= out_n;
      cnt_q <= cnt_n;
      on_q  <= out_n & ~out_q;
      off_q <= ~out_n & out_q;
      alm_q <= alm_n;
    end
  end

  assign out_o   = out_q;
  assign on_o    = on_q;
  assign off_o   = off_q;
  assign alarm_o = alm_q;

  assert_disabled_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl_i[CTL_EN]) |-> (out_o == $past(ctrl_i[CTL_INIT])));

  assert_alarm_drop_R6: assert property (@(posedge clk) disable iff (rst)
    alarm_o |-> (!out_o && $past(out_o) && off_o));

  assert_count_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_q) != '0 && cnt_q == $past(cnt_q) - TIME_W'(1) && !$past(set_i || clr_i))
      |-> $past(tick_i));

  assert_on_edge_R9: assert property (@(posedge clk) disable iff (rst)
    on_o |-> (out_o && !$past(out_o)));

  assert_off_edge_R9: assert property (@(posedge clk) disable iff (rst)
    off_o |-> (!out_o && $past(out_o)));
endmodule

// File: rtl/outbank_guard.sv
module outbank_guard
  import outbank_pkg::*;
#(
  parameter int N_OUT  = 8,
  parameter int TIME_W = 16,
  parameter int ADDR_W = $clog2(3 * N_OUT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [N_OUT-1:0]  set_mask,
  input  logic [N_OUT-1:0]  clr_mask,
  input  logic              tick_1s,
  output logic [N_OUT-1:0]  out_pins,
  output logic [N_OUT-1:0]  on_evt,
  output logic [N_OUT-1:0]  off_evt,
  output logic [N_OUT-1:0]  alarm_evt
);
  byte_t [N_OUT-1:0]             ctrl;
  logic  [N_OUT-1:0][TIME_W-1:0] ptime;

  outbank_regs #(.N_OUT(N_OUT), .TIME_W(TIME_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ctrl_o(ctrl), .ptime_o(ptime)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_ch
    outbank_chan #(.TIME_W(TIME_W)) u_ch (
      .clk(clk), .rst(rst), .ctrl_i(ctrl[i]), .ptime_i(ptime[i]),
      .set_i(set_mask[i]), .clr_i(clr_mask[i]), .tick_i(tick_1s),
      .out_o(out_pins[i]), .on_o(on_evt[i]), .off_o(off_evt[i]),
      .alarm_o(alarm_evt[i])
    );
  end

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    (on_evt & off_evt) == '0);
endmodule

// File: tb/outbank_guard_tb.sv
`timescale 1ns/1ps
module outbank_guard_tb;
  localparam int N  = 8;
  localparam int AW = 5;

  logic clk = 0, rst = 1, wr_en = 0, tick = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [N-1:0] set_m = '0, clr_m = '0, outp, on_e, off_e, alm_e;
  int runs = 0, fails = 0;

  always #4 clk = ~clk;

  outbank_guard u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .set_mask(set_m), .clr_mask(clr_m),
    .tick_1s(tick), .out_pins(outp), .on_evt(on_e), .off_evt(off_e),
    .alarm_evt(alm_e)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = AW'(a); wr_data = 8'(d);
    cyc();
    wr_en = 0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    rd_addr = AW'(a);
    cyc();
    d = rd_data;
  endtask

  task automatic pulse_tick();
    tick = 1; cyc(); tick = 0;
  endtask

  task automatic cmd(logic [N-1:0] s, logic [N-1:0] c);
    set_m = s; clr_m = c; cyc(); set_m = '0; clr_m = '0;
  endtask

  // {set, clr, expected outputs}
  localparam logic [23:0] VEC [8] = '{
    {8'h01, 8'h00, 8'h01}, {8'hF0, 8'h00, 8'hF1}, {8'h00, 8'h10, 8'hE1},
    {8'hFF, 8'h00, 8'hFF}, {8'h00, 8'hAA, 8'h55}, {8'h0F, 8'h0F, 8'h50},
    {8'h00, 8'hFF, 8'h00}, {8'h81, 8'h01, 8'h80}
  };

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [N-1:0] prev;
    repeat (3) cyc();
    // R1 reset state
    chk("R1 outputs", 16'(outp), 0);
    chk("R1 strobes", 16'(on_e | off_e | alm_e), 0);
    rst = 0;
    cyc();
    rd(0, d);  chk("R1 ctrl0", 16'(d), 0);
    rd(9, d);  chk("R1 time lo", 16'(d), 0);

    // R2/R5 vector walk: enable all outputs, no protection
    for (int i = 0; i < N; i++) wr(i, 8'h80);
    cyc();
    rd(3, d); chk("R2 ctrl3 readback", 16'(d), 16'h80);
    rd(30, d); chk("R2 unmapped", 16'(d), 0);
    prev = '0;
    for (int k = 0; k < 8; k++) begin
      cmd(VEC[k][23:16], VEC[k][15:8]);
      chk("R5 vector out", 16'(outp), 16'(VEC[k][7:0]));
      chk("R9 vector on", 16'(on_e), 16'(VEC[k][7:0] & ~prev));
      chk("R9 vector off", 16'(off_e), 16'(~VEC[k][7:0] & prev));
      prev = VEC[k][7:0];
    end
    cmd('0, 8'hFF);

    // R3 staged MSB
    wr(N + 10, 8'h12);
    rd(N + 10, d); chk("R3 msb before lsb", 16'(d), 0);
    wr(N + 11, 8'h34);
    rd(N + 10, d); chk("R3 msb after lsb", 16'(d), 16'h12);
    rd(N + 11, d); chk("R3 lsb", 16'(d), 16'h34);

    // R4 disabled output follows init bit and ignores commands
    wr(1, 8'h01); cyc();
    chk("R4 init high", 16'(outp[1]), 1);
    cmd(8'h00, 8'h02);
    chk("R4 clr ignored", 16'(outp[1]), 1);
    wr(1, 8'h00); cyc();
    chk("R4 init low", 16'(outp[1]), 0);
    cmd(8'h02, 8'h00);
    chk("R4 set ignored", 16'(outp[1]), 0);

    // R6 timeout after 3 ticks on channel 2
    wr(2, 8'h84); wr(N + 4, 0); wr(N + 5, 3);
    cmd(8'h04, 0);
    chk("R6 raised", 16'(outp[2]), 1);
    pulse_tick(); pulse_tick();
    chk("R6 high after 2 ticks", 16'(outp[2]), 1);
    pulse_tick();
    chk("R6 dropped", 16'(outp[2]), 0);
    chk("R6 alarm", 16'(alm_e), 16'h04);
    chk("R9 off on timeout", 16'(off_e), 16'h04);
    cyc();
    chk("R6 alarm one cycle", 16'(alm_e), 0);

    // R7 restart by rewrite
    cmd(8'h04, 0);
    pulse_tick(); pulse_tick();
    cmd(8'h04, 0);
    chk("R7 no on strobe on rewrite", 16'(on_e), 0);
    pulse_tick(); pulse_tick();
    chk("R7 still high after reload", 16'(outp[2]), 1);
    pulse_tick();
    chk("R7 dropped after reload", 16'(outp[2]), 0);

    // R8 unarmed and zero-time channels never expire
    wr(3, 8'h80); wr(N + 6, 0); wr(N + 7, 2);
    wr(4, 8'h84);
    cmd(8'h18, 0);
    for (int t = 0; t < 5; t++) pulse_tick();
    chk("R8 no timeout", 16'(outp[4:3]), 16'h3);
    chk("R8 no alarm", 16'(alm_e), 0);

    cyc();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule